// File: doc/BRIEF.md
# Fractional-N Divide Ratio Sequencer

This block feeds the feedback divider of a fractional-N synthesizer loop. On every reference comparison cycle (a one-clock `ref_tick` strobe) it emits one integer divide value. The value is an integer part built from a swallow word and a binary word for an 8/9 dual-modulus prescaler, plus a carry from a first-order delta-sigma accumulator. Over time the carries average out to a fractional numerator divided by a modulus.

The modulus is not a power of two. It is 1920 or 1968, picked by a reference-select bit. A half-step bit adds half of one fractional step. It does this by doubling the modulus and using an odd numerator. The controlling logic loads new words with a load strobe. Those words are held back and take effect together on the next enabled reference cycle. At that cycle the accumulator restarts from zero. An enable input stops the block while low and resumes it when it returns high.

Top module: `fracn_div_seq`

## Requirements
- R1: After reset `div_valid` is 0 and `div_value` is 0.
- R2: For each clock on which `ref_tick` and `enable` are both 1, `div_valid` is 1 on the following clock. `div_valid` is 0 on every other clock.
- R3: The divide value is 8*B + A + c, where B is `bin_word`, A is `swal_word` and c is the accumulator carry of that cycle (0 or 1). For example, B=5, A=3 with a zero numerator gives 43 on every cycle.
- R4: On every enabled tick the accumulator adds the effective numerator. When the sum is at least the modulus M, it subtracts M and c is 1 for that cycle. Otherwise c is 0.
- R5: M is 1920 when `ref_sel` is 0 and 1968 when `ref_sel` is 1.
- R6: When `half_step` is 1, M is doubled and the effective numerator is 2*FN+1. When `half_step` is 0, the effective numerator is FN.
- R7: A numerator FN equal to or above the undoubled modulus is treated as that modulus minus 1.
- R8: A `bin_word` value of 0 or 1 is treated as 2.
- R9: Words presented with `cfg_load`=1 are captured, with later loads overriding earlier ones. Ticks before the next enabled tick keep using the previous words. The first enabled tick after a load uses the new words and starts its sum from an accumulator of 0.
- R10: Ticks while `enable` is 0 produce no `div_valid`. The accumulator and the words are held. Loads are still captured. After `enable` returns to 1, the sequence continues from the held accumulator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick | input | 1 | One-clock strobe per reference comparison cycle |
| cfg_load | input | 1 | Captures the word inputs for the next enabled tick |
| swal_word | input | 3 | Swallow word A, 0..7 |
| bin_word | input | 4 | Binary word B, 2..15 |
| frac_num | input | 11 | Fractional numerator FN |
| ref_sel | input | 1 | Modulus select: 0 gives 1920, 1 gives 1968 |
| half_step | input | 1 | Adds half a fractional step |
| enable | input | 1 | Block runs while 1 |
| div_value | output | 8 | Divide value for the current reference cycle |
| div_valid | output | 1 | Marks a new `div_value` |

## Verification
The assertions check several things on every clock:
- `div_valid` follows an enabled tick by exactly one clock.
- The effective numerator stays below the effective modulus.
- The clamped B word never drops below 2.
- The settled accumulator stays below its modulus.
- The accumulator does not move without an enabled tick.

Only the bench scenarios can show the following, because each depends on the exact carry pattern over a sequence of ticks:
- that the carries come out in the right cycles for each modulus;
- that the half-step arithmetic is correct;
- that a load takes effect at the right tick and no earlier;
- that a held accumulator resumes where it stopped.

// File: rtl/fracn_pkg.sv
package fracn_pkg;
  localparam int DEF_A_W    = 3;
  localparam int DEF_B_W    = 4;
  localparam int DEF_FN_W   = 11;
  localparam int DEF_MOD_LO = 1920;
  localparam int DEF_MOD_HI = 1968;
  localparam int DEF_PRESC  = 8;
  localparam int DEF_B_MIN  = 2;
endpackage

// File: rtl/fracn_cfg_stage.sv
module fracn_cfg_stage
  import fracn_pkg::*;
#(
  parameter int A_W    = DEF_A_W,
  parameter int B_W    = DEF_B_W,
  parameter int FN_W   = DEF_FN_W,
  parameter int MOD_LO = DEF_MOD_LO,
  parameter int MOD_HI = DEF_MOD_HI,
  parameter int B_MIN  = DEF_B_MIN,
  localparam int MOD_W = $clog2(2 * MOD_HI)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_load,
  input  logic [A_W-1:0]   a_in,
  input  logic [B_W-1:0]   b_in,
  input  logic [FN_W-1:0]  fn_in,
  input  logic             sel_in,
  input  logic             half_in,
  input  logic             tick_en,
  output logic [A_W-1:0]   a_o,
  output logic [B_W-1:0]   b_o,
  output logic [MOD_W-1:0] mod_o,
  output logic [MOD_W-1:0] num_o,
  output logic             restart_o
);
  logic [A_W-1:0]  stg_a, act_a, use_a;
  logic [B_W-1:0]  stg_b, act_b, use_b;
  logic [FN_W-1:0] stg_fn, act_fn, use_fn;
  logic            stg_sel, act_sel, use_sel;
  logic            stg_half, act_half, use_half;
  logic            pending;
  logic [MOD_W-1:0] base_mod, fn_ext, fn_clamped;

  always_ff @(posedge clk) begin
    if (rst) begin
      stg_a <= '0; stg_b <= B_W'(B_MIN); stg_fn <= '0; stg_sel <= 1'b0; stg_half <= 1'b0;
      act_a <= '0; act_b <= B_W'(B_MIN); act_fn <= '0; act_sel <= 1'b0; act_half <= 1'b0;
      pending <= 1'b0;
    end else begin
      if (cfg_load) begin
        stg_a <= a_in; stg_b <= b_in; stg_fn <= fn_in;
        stg_sel <= sel_in; stg_half <= half_in;
      end
      if (tick_en && pending) begin
        act_a <= stg_a; act_b <= stg_b; act_fn <= stg_fn;
        act_sel <= stg_sel; act_half <= stg_half;
      end
      if (tick_en) pending <= cfg_load;
      else if (cfg_load) pending <= 1'b1;
    end
  end

  always_comb begin
    use_a    = pending ? stg_a    : act_a;
    use_b    = pending ? stg_b    : act_b;
    use_fn   = pending ? stg_fn   : act_fn;
    use_sel  = pending ? stg_sel  : act_sel;
    use_half = pending ? stg_half : act_half;
    base_mod = use_sel ? MOD_W'(MOD_HI) : MOD_W'(MOD_LO);
    fn_ext   = MOD_W'(use_fn);
    fn_clamped = (fn_ext >= base_mod) ? base_mod - 1'b1 : fn_ext;
    if (use_half) begin
      mod_o = base_mod << 1;
      num_o = (fn_clamped << 1) | MOD_W'(1);
    end else begin
      mod_o = base_mod;
      num_o = fn_clamped;
    end
    a_o = use_a;
    b_o = (use_b < B_W'(B_MIN)) ? B_W'(B_MIN) : use_b;
    restart_o = pending;
  end

  // R7
  num_in_range_chk: assert property (@(posedge clk) disable iff (rst) num_o < mod_o)
    else $error("effective numerator not below modulus");
  // R8
  b_floor_chk: assert property (@(posedge clk) disable iff (rst) b_o >= B_W'(B_MIN))
    else $error("binary word below floor");
endmodule

// File: rtl/fracn_dsm_acc.sv
module fracn_dsm_acc #(
  parameter int MOD_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_en,
  input  logic             restart,
  input  logic [MOD_W-1:0] mod_i,
  input  logic [MOD_W-1:0] num_i,
  output logic             carry_o
);
  logic [MOD_W-1:0] acc_q, acc_d;
  logic [MOD_W:0]   sum;

  always_comb begin
    sum     = (restart ? {(MOD_W+1){1'b0}} : {1'b0, acc_q}) + {1'b0, num_i};
    carry_o = (sum >= {1'b0, mod_i});
    acc_d   = carry_o ? MOD_W'(sum - {1'b0, mod_i}) : sum[MOD_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)          acc_q <= '0;
    else if (tick_en) acc_q <= acc_d;
  end

  // R4
  acc_below_mod_chk: assert property (@(posedge clk) disable iff (rst) !restart |-> acc_q < mod_i)
    else $error("accumulator reached modulus");
  // R10
  acc_hold_chk: assert property (@(posedge clk) disable iff (rst) !tick_en |=> $stable(acc_q))
    else $error("accumulator moved without enabled tick");
endmodule

// File: rtl/fracn_div_seq.sv
module fracn_div_seq
  import fracn_pkg::*;
#(
  parameter int A_W    = DEF_A_W,
  parameter int B_W    = DEF_B_W,
  parameter int FN_W   = DEF_FN_W,
  parameter int MOD_LO = DEF_MOD_LO,
  parameter int MOD_HI = DEF_MOD_HI,
  parameter int PRESC  = DEF_PRESC,
  parameter int B_MIN  = DEF_B_MIN,
  localparam int MOD_W = $clog2(2 * MOD_HI),
  localparam int DIV_W = $clog2(PRESC * (2**B_W - 1) + 2**A_W + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ref_tick,
  input  logic             cfg_load,
  input  logic [A_W-1:0]   swal_word,
  input  logic [B_W-1:0]   bin_word,
  input  logic [FN_W-1:0]  frac_num,
  input  logic             ref_sel,
  input  logic             half_step,
  input  logic             enable,
  output logic [DIV_W-1:0] div_value,
  output logic             div_valid
);
  logic             tick_en, restart, carry;
  logic [A_W-1:0]   a_eff;
  logic [B_W-1:0]   b_eff;
  logic [MOD_W-1:0] mod_eff, num_eff;
  logic [DIV_W-1:0] div_d;

  assign tick_en = ref_tick & enable;

  fracn_cfg_stage #(
    .A_W(A_W), .B_W(B_W), .FN_W(FN_W), .MOD_LO(MOD_LO), .MOD_HI(MOD_HI), .B_MIN(B_MIN)
  ) cfg_i (
    .clk(clk), .rst(rst), .cfg_load(cfg_load),
    .a_in(swal_word), .b_in(bin_word), .fn_in(frac_num),
    .sel_in(ref_sel), .half_in(half_step), .tick_en(tick_en),
    .a_o(a_eff), .b_o(b_eff), .mod_o(mod_eff), .num_o(num_eff), .restart_o(restart)
  );

  fracn_dsm_acc #(.MOD_W(MOD_W)) acc_i (
    .clk(clk), .rst(rst), .tick_en(tick_en), .restart(restart),
    .mod_i(mod_eff), .num_i(num_eff), .carry_o(carry)
  );

  assign div_d = DIV_W'(PRESC) * DIV_W'(b_eff) + DIV_W'(a_eff) + DIV_W'(carry);

  always_ff @(posedge clk) begin
    if (rst) begin
      div_value <= '0;
      div_valid <= 1'b0;
    end else begin
      div_valid <= tick_en;
      if (tick_en) div_value <= div_d;
    end
  end

  // R2
  valid_follows_tick_chk: assert property (@(posedge clk) disable iff (rst) div_valid |-> $past(tick_en))
    else $error("valid without enabled tick");
  // R2
  tick_gives_valid_chk: assert property (@(posedge clk) disable iff (rst) tick_en |=> div_valid)
    else $error("enabled tick without valid");
  // R3
  div_floor_chk: assert property (@(posedge clk) disable iff (rst)
    div_valid |-> div_value >= DIV_W'(PRESC * B_MIN))
    else $error("divide value below floor");
endmodule

// File: tb/fracn_div_seq_tb.sv
module fracn_div_seq_tb_top;
  typedef struct {
    int    val;
    string tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ref_tick = 1'b0, cfg_load = 1'b0;
  logic [2:0] swal_word = '0;
  logic [3:0] bin_word = '0;
  logic [10:0] frac_num = '0;
  logic       ref_sel = 1'b0, half_step = 1'b0, enable = 1'b0;
  logic [7:0] div_value;
  logic       div_valid;

  int checks = 0, fails = 0;
  exp_t q[$];

  // model state
  int s_a, s_b, s_fn, s_sel, s_half, m_a, m_b, m_fn, m_sel, m_half, m_acc;
  bit m_pend;

  always #4 clk = ~clk;

  fracn_div_seq dut_i (
    .clk(clk), .rst(rst), .ref_tick(ref_tick), .cfg_load(cfg_load),
    .swal_word(swal_word), .bin_word(bin_word), .frac_num(frac_num),
    .ref_sel(ref_sel), .half_step(half_step), .enable(enable),
    .div_value(div_value), .div_valid(div_valid)
  );

  task automatic load_cfg(int a, int b, int fn, int sel, int half);
    @(negedge clk);
    swal_word = 3'(a); bin_word = 4'(b); frac_num = 11'(fn);
    ref_sel = sel[0]; half_step = half[0]; cfg_load = 1'b1;
    s_a = a; s_b = b; s_fn = fn; s_sel = sel; s_half = half; m_pend = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
  endtask

  function automatic int model_step();
    int b, m, fn, n, sum, c;
    if (m_pend) begin
      m_a = s_a; m_b = s_b; m_fn = s_fn; m_sel = s_sel; m_half = s_half;
      m_acc = 0; m_pend = 1'b0;
    end
    b  = (m_b < 2) ? 2 : m_b;
    m  = m_sel ? 1968 : 1920;
    fn = (m_fn >= m) ? m - 1 : m_fn;
    n  = fn;
    if (m_half) begin m = 2 * m; n = 2 * fn + 1; end
    sum = m_acc + n;
    c = (sum >= m) ? 1 : 0;
    m_acc = c ? sum - m : sum;
    return 8 * b + m_a + c;
  endfunction

  task automatic do_tick(string tag);
    exp_t e;
    @(negedge clk);
    ref_tick = 1'b1;
    if (enable) begin
      e.val = model_step();
      e.tag = tag;
      q.push_back(e);
    end
    @(negedge clk);
    ref_tick = 1'b0;
    if (!enable) begin
      checks++;
      if (div_valid) begin
        fails++;
        $display("FAIL %s: div_valid=%0b expected 0 while disabled", tag, div_valid);
      end
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (!rst && div_valid) begin
      checks++;
      if (q.size() == 0) begin
        fails++;
        $display("FAIL R2: unexpected div_valid, value %0d expected none", div_value);
      end else begin
        exp_t e;
        e = q.pop_front();
        if (int'(div_value) != e.val) begin
          fails++;
          $display("FAIL %s: div_value=%0d expected %0d", e.tag, div_value, e.val);
        end
      end
    end
  end

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    m_pend = 1'b0; m_acc = 0; m_a = 0; m_b = 2; m_fn = 0; m_sel = 0; m_half = 0;
    s_a = 0; s_b = 2; s_fn = 0; s_sel = 0; s_half = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    checks++;
    if (div_valid !== 1'b0) begin fails++; $display("FAIL R1: div_valid=%0b expected 0", div_valid); end
    checks++;
    if (div_value !== 8'd0) begin fails++; $display("FAIL R1: div_value=%0d expected 0", div_value); end

    enable = 1'b1;
    // R3: integer only, 8*5+3 = 43
    load_cfg(3, 5, 0, 0, 0);
    repeat (4) do_tick("R3");
    // R4: FN=960 of 1920 alternates carry
    load_cfg(1, 9, 960, 0, 0);
    repeat (6) do_tick("R4");
    // R5: same numerator, two moduli
    load_cfg(0, 4, 1919, 0, 0);
    repeat (5) do_tick("R5");
    load_cfg(0, 4, 1919, 1, 0);
    repeat (5) do_tick("R5");
    load_cfg(7, 15, 984, 1, 0);
    repeat (4) do_tick("R5");
    // R6: half step
    load_cfg(2, 6, 959, 0, 1);
    repeat (6) do_tick("R6");
    load_cfg(2, 6, 0, 1, 1);
    repeat (4) do_tick("R6");
    // R7: numerator clamp
    load_cfg(0, 3, 2047, 0, 0);
    repeat (5) do_tick("R7");
    load_cfg(0, 3, 1970, 1, 1);
    repeat (4) do_tick("R7");
    // R8: binary word floor
    load_cfg(5, 0, 0, 0, 0);
    repeat (2) do_tick("R8");
    load_cfg(5, 1, 0, 0, 0);
    repeat (2) do_tick("R8");
    // R9: staged load, later load overrides, restart of accumulator
    load_cfg(0, 7, 1500, 0, 0);
    repeat (3) do_tick("R9");
    load_cfg(1, 2, 0, 0, 0);
    load_cfg(4, 10, 1000, 1, 0);
    repeat (4) do_tick("R9");
    // R10: disabled ticks, load while disabled, resume
    load_cfg(2, 8, 1300, 0, 0);
    repeat (2) do_tick("R10");
    enable = 1'b0;
    repeat (3) do_tick("R10");
    enable = 1'b1;
    repeat (3) do_tick("R10");
    enable = 1'b0;
    load_cfg(6, 11, 500, 1, 1);
    repeat (2) do_tick("R10");
    enable = 1'b1;
    repeat (4) do_tick("R10");
    // R2: spaced ticks
    repeat (3) @(negedge clk);
    do_tick("R2");
    repeat (2) @(negedge clk);

    checks++;
    if (q.size() != 0) begin
      fails++;
      $display("FAIL R2: %0d results missing, expected 0", q.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule